// File: doc/BRIEF.md
# Handshaked Byte Transfer Engine

This block moves bytes between a host and a small device controller over three active-low handshake wires. The host drives a transfer-in-progress line and an acknowledge line. The device drives a transfer-request line back. A single shift register sits between the two sides. A direction input decides which way bytes travel. Host-to-device bytes are appended to a 16-entry output buffer. Device-to-host bytes are fetched one by one from a 128-entry input buffer.

Bytes do not move on a clock count. A byte moves when the level of either host handshake wire differs from the level it had on the previous clock. Every accepted byte sets a shift interrupt flag. Every end of transfer sets that flag too. When the host releases transfer-in-progress after sending bytes, the engine emits a one-cycle packet pulse with the byte count. Software or firmware on the device side loads reply packets through a write-and-commit port. It reads completed host packets through a combinational read port. The contents of a packet are not interpreted here.

All handshake inputs are assumed to be synchronous to `clk` already.

Top module: `hbt_engine`

## Requirements
- R1: After reset, `treq_n` is 1, `shift_irq` is 0, `pkt_valid` is 0 and `sr_q` is 0.
- R2: While `tip_n` is 0 and `dir_out` is 1, each cycle in which `tip_n` or `tack_n` differs from its previous sampled level appends `sr_q` to the output buffer and sets `shift_irq`. Both results are visible after that clock edge.
- R3: The output buffer keeps at most 16 bytes. Further handshake changes in the output direction store nothing and do not set `shift_irq`.
- R4: While `tip_n` is 0 and `dir_out` is 0, each handshake change with input bytes pending loads the next input byte into `sr_q` and sets `shift_irq`. With no byte pending, or with no change, `sr_q` and `shift_irq` are left alone.
- R5: The clock edge that loads the last pending input byte also drives `treq_n` to 1.
- R6: When `tip_n` is 1 in both the current and the previous sample and `tack_n` changes, `treq_n` takes the new `tack_n` level and `shift_irq` is set.
- R7: When `tip_n` goes from 0 to 1, `shift_irq` is always set. If the output buffer holds bytes, `pkt_valid` is 1 for exactly one cycle with `pkt_len` equal to the count, and the count returns to 0.
- R8: While `tip_n` is 1 with input bytes pending and no idle `tack_n` change, `treq_n` is driven to 0.
- R9: `in_wr_en` writes `in_wr_data` at `in_wr_addr`. `in_commit` sets the pending length to `in_len` and restarts the read position at byte 0.
- R10: `sr_ack` clears `shift_irq`. A set in the same cycle takes priority.
- R11: `sr_wr_en` loads `sr_wr_data` into the shift register, which `sr_q` shows on the next cycle. An input-direction byte load in the same cycle wins.
- R12: `out_rd_data` combinationally shows the output buffer byte at `out_rd_addr`. Byte 0 is the first byte the host sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tip_n | input | 1 | Host transfer in progress, active low |
| tack_n | input | 1 | Host acknowledge, active low |
| treq_n | output | 1 | Device transfer request, active low |
| dir_out | input | 1 | 1 = host-to-device, 0 = device-to-host |
| sr_wr_en | input | 1 | Host write strobe for the shift register |
| sr_wr_data | input | 8 | Host write data for the shift register |
| sr_ack | input | 1 | Clears the shift interrupt flag |
| sr_q | output | 8 | Shift register contents |
| shift_irq | output | 1 | Shift interrupt flag |
| in_wr_en | input | 1 | Device write strobe into the input buffer |
| in_wr_addr | input | 7 | Input buffer write address |
| in_wr_data | input | 8 | Input buffer write data |
| in_commit | input | 1 | Publishes a new input packet |
| in_len | input | 8 | Length of the committed input packet (0 to 128) |
| out_rd_addr | input | 4 | Output buffer read address |
| out_rd_data | output | 8 | Output buffer read data |
| pkt_valid | output | 1 | One-cycle pulse: host packet complete |
| pkt_len | output | 5 | Byte count of the completed host packet |

## Verification
A handshake change presented before clock edge k produces its byte move, flag set and request change on edge k. The bench therefore drives inputs one time unit after a rising edge and samples results one time unit after the next rising edge.

An input packet commit shows up on `treq_n` one edge later than a handshake change does. The first edge stores the length, and the second applies the idle rule. The bench steps twice before it checks `treq_n`.

`pkt_valid` is registered on the edge that sees `tip_n` released. A monitor samples it at the following falling edge. The monitor then compares the length and every byte, read through `out_rd_addr`, against the packets the driver queued.

// File: rtl/hbt_pkg.sv
// Shared types for the handshaked byte transfer engine.
package hbt_pkg;

    // Outcome of the handshake decode in one clock cycle.
    typedef enum logic [2:0] {
        HS_NONE,   // transfer active, nothing moves
        HS_PUSH,   // host byte stored into output buffer
        HS_POP,    // next input byte loaded into shift register
        HS_SYNC,   // idle: request line follows acknowledge
        HS_END,    // transfer-in-progress released
        HS_IDLE    // idle, no acknowledge change
    } hs_event_e;

endpackage

// File: rtl/hbt_hs_sampler.sv
// Keeps the previous level of both host handshake lines and reports changes.
// Assumes tip_n and tack_n are already synchronous to clk.
module hbt_hs_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tip_n,
    input  logic tack_n,
    output logic pair_chg,
    output logic tack_chg,
    output logic tip_rise,
    output logic idle_steady
);
    logic prev_tip_n;
    logic prev_tack_n;

    // Remember last sampled levels; the lines reset to their inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tip_n  <= 1'b1;
            prev_tack_n <= 1'b1;
        end else begin
            prev_tip_n  <= tip_n;
            prev_tack_n <= tack_n;
        end
    end

    // Change and level qualifiers relative to the previous sample.
    always_comb begin
        tack_chg    = tack_n != prev_tack_n;
        pair_chg    = tack_chg || (tip_n != prev_tip_n);
        tip_rise    = tip_n && !prev_tip_n;
        idle_steady = tip_n && prev_tip_n;
    end
endmodule

// File: rtl/hbt_in_buf.sv
// Device-to-host byte store: one synchronous write port and one
// combinational read port. Contents are not reset.
module hbt_in_buf #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Device-side write of packet bytes.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/hbt_out_buf.sv
// Host-to-device byte store with an append pointer that doubles as the count.
// Assumes push is only raised when not full and never together with clr.
module hbt_out_buf #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          clr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];

    // Byte count: cleared at end of packet, advanced on each stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (push)     count <= count + CW'(1);
    end

    // Store the byte at the current append position.
    always_ff @(posedge clk) begin
        if (push) mem[count[AW-1:0]] <= wr_data;
    end

    assign full    = count == CW'(DEPTH);
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/hbt_engine.sv
// Handshaked byte transfer engine (top). Decodes changes on the host
// handshake lines into byte moves between a shift register and two buffers,
// drives the device request line, and reports completed host packets.
// Assumes in_len never exceeds IN_DEPTH.
module hbt_engine
    import hbt_pkg::*;
#(
    parameter int DW        = 8,
    parameter int IN_DEPTH  = 128,
    parameter int OUT_DEPTH = 16,
    localparam int IN_AW    = $clog2(IN_DEPTH),
    localparam int IN_CW    = $clog2(IN_DEPTH + 1),
    localparam int OUT_AW   = $clog2(OUT_DEPTH),
    localparam int OUT_CW   = $clog2(OUT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tip_n,
    input  logic              tack_n,
    output logic              treq_n,
    input  logic              dir_out,
    input  logic              sr_wr_en,
    input  logic [DW-1:0]     sr_wr_data,
    input  logic              sr_ack,
    output logic [DW-1:0]     sr_q,
    output logic              shift_irq,
    input  logic              in_wr_en,
    input  logic [IN_AW-1:0]  in_wr_addr,
    input  logic [DW-1:0]     in_wr_data,
    input  logic              in_commit,
    input  logic [IN_CW-1:0]  in_len,
    input  logic [OUT_AW-1:0] out_rd_addr,
    output logic [DW-1:0]     out_rd_data,
    output logic              pkt_valid,
    output logic [OUT_CW-1:0] pkt_len
);
    logic              pair_chg, tack_chg, tip_rise, idle_steady;
    logic [IN_CW-1:0]  in_idx, in_len_q;
    logic [DW-1:0]     in_byte;
    logic [OUT_CW-1:0] out_count;
    logic              out_full;
    logic              in_pending, in_last;
    hs_event_e         ev;

    hbt_hs_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .tack_n(tack_n),
        .pair_chg(pair_chg), .tack_chg(tack_chg),
        .tip_rise(tip_rise), .idle_steady(idle_steady)
    );

    hbt_in_buf #(.DEPTH(IN_DEPTH), .DW(DW)) u_ibuf (
        .clk(clk), .wr_en(in_wr_en), .wr_addr(in_wr_addr),
        .wr_data(in_wr_data), .rd_addr(in_idx[IN_AW-1:0]), .rd_data(in_byte)
    );

    hbt_out_buf #(.DEPTH(OUT_DEPTH), .DW(DW)) u_obuf (
        .clk(clk), .rst_n(rst_n), .push(ev == HS_PUSH), .clr(ev == HS_END),
        .wr_data(sr_q), .rd_addr(out_rd_addr), .rd_data(out_rd_data),
        .count(out_count), .full(out_full)
    );

    // Pending-byte status of the input packet.
    always_comb begin
        in_pending = in_idx < in_len_q;
        in_last    = (in_idx + IN_CW'(1)) >= in_len_q;
    end

    // Classify this cycle's handshake situation.
    always_comb begin
        if (!tip_n) begin
            if (dir_out) ev = (pair_chg && !out_full)  ? HS_PUSH : HS_NONE;
            else         ev = (pair_chg && in_pending) ? HS_POP  : HS_NONE;
        end else if (idle_steady && tack_chg) begin
            ev = HS_SYNC;
        end else if (tip_rise) begin
            ev = HS_END;
        end else begin
            ev = HS_IDLE;
        end
    end

    // Shift register: input-byte load wins over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)             sr_q <= '0;
        else if (ev == HS_POP)  sr_q <= in_byte;
        else if (sr_wr_en)      sr_q <= sr_wr_data;
    end

    // Shift interrupt flag: any byte move or transfer edge sets, ack clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_irq <= 1'b0;
        else if (ev inside {HS_PUSH, HS_POP, HS_SYNC, HS_END})
            shift_irq <= 1'b1;
        else if (sr_ack)
            shift_irq <= 1'b0;
    end

    // Device request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            treq_n <= 1'b1;
        end else begin
            unique case (ev)
                HS_POP:          if (in_last) treq_n <= 1'b1;
                HS_SYNC:         treq_n <= tack_n;
                HS_END, HS_IDLE: if (in_pending) treq_n <= 1'b0;
                default:         ;
            endcase
        end
    end

    // Input packet length and read position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_idx   <= '0;
            in_len_q <= '0;
        end else if (in_commit) begin
            in_idx   <= '0;
            in_len_q <= in_len;
        end else if (ev == HS_POP) begin
            in_idx   <= in_idx + IN_CW'(1);
        end
    end

    // Completed host packet report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_valid <= 1'b0;
            pkt_len   <= '0;
        end else begin
            pkt_valid <= (ev == HS_END) && (out_count != '0);
            if (ev == HS_END) pkt_len <= out_count;
        end
    end
endmodule

// File: rtl/hbt_checker.sv
// Protocol properties of hbt_engine, attached by bind.
module hbt_checker #(
    parameter int OUT_DEPTH = 16,
    parameter int IN_CW     = 8,
    localparam int OUT_CW   = $clog2(OUT_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tip_n,
    input logic              sr_ack,
    input logic              shift_irq,
    input logic              pkt_valid,
    input logic [OUT_CW-1:0] pkt_len,
    input logic [OUT_CW-1:0] out_cnt,
    input logic [IN_CW-1:0]  in_idx,
    input logic [IN_CW-1:0]  in_len_q
);
    a_r3_out_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= OUT_CW'(OUT_DEPTH));

    a_r7_pkt_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_len != '0);

    a_r7_pkt_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> ($past(tip_n) && !$past(tip_n, 2)));

    a_r7_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> out_cnt == '0);

    a_r10_clear_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_irq) |-> $past(sr_ack));

    a_r9_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_idx <= in_len_q);
endmodule

bind hbt_engine hbt_checker #(.OUT_DEPTH(OUT_DEPTH), .IN_CW(IN_CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .sr_ack(sr_ack),
    .shift_irq(shift_irq), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .out_cnt(out_count), .in_idx(in_idx), .in_len_q(in_len_q)
);

// File: tb/sim_hbt_engine.sv
`timescale 1ns/10ps
// Scoreboard bench: drivers queue expected host packets, a monitor compares
// each reported packet; other results are checked directly after each edge.
module sim_hbt_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tip_n = 1'b1, tack_n = 1'b1, dir_out = 1'b0;
    logic       sr_wr_en = 1'b0, sr_ack = 1'b0;
    logic [7:0] sr_wr_data = '0;
    logic       in_wr_en = 1'b0, in_commit = 1'b0;
    logic [6:0] in_wr_addr = '0;
    logic [7:0] in_wr_data = '0;
    logic [7:0] in_len = '0;
    logic [3:0] out_rd_addr = '0;
    logic       treq_n, shift_irq, pkt_valid;
    logic [7:0] sr_q, out_rd_data;
    logic [4:0] pkt_len;

    int checks = 0, errors = 0, pkts_seen = 0;
    bit done = 1'b0;
    int         exp_len_q[$];
    logic [7:0] exp_byte_q[$];

    always #2 clk = ~clk;

    hbt_engine u0 (
        .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .tack_n(tack_n),
        .treq_n(treq_n), .dir_out(dir_out), .sr_wr_en(sr_wr_en),
        .sr_wr_data(sr_wr_data), .sr_ack(sr_ack), .sr_q(sr_q),
        .shift_irq(shift_irq), .in_wr_en(in_wr_en), .in_wr_addr(in_wr_addr),
        .in_wr_data(in_wr_data), .in_commit(in_commit), .in_len(in_len),
        .out_rd_addr(out_rd_addr), .out_rd_data(out_rd_data),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_irq();
        sr_ack = 1'b1; step(); sr_ack = 1'b0;
    endtask

    // Host sends n bytes base, base+1, ...; queues what the packet must hold.
    task automatic host_send(input int n, input logic [7:0] base);
        int kept;
        kept = (n > 16) ? 16 : n;
        dir_out = 1'b1;
        exp_len_q.push_back(kept);
        for (int i = 0; i < kept; i++) exp_byte_q.push_back(base + 8'(i));
        for (int i = 0; i < n; i++) begin
            sr_wr_en = 1'b1; sr_wr_data = base + 8'(i); step(); sr_wr_en = 1'b0;
            chk("R11 sr write", sr_q, base + 8'(i));
            if (i >= 16) clear_irq();
            if (i == 0) tip_n = 1'b0; else tack_n = ~tack_n;
            step();
            if (i < 16) chk("R2 byte stored irq", shift_irq, 1);
            else        chk("R3 overflow no irq", shift_irq, 0);
        end
        clear_irq();
        tip_n = 1'b1; step();
        chk("R7 release irq", shift_irq, 1);
        step();
    endtask

    // Monitor: compares each packet against the queued expectation.
    always @(negedge clk) begin
        if (pkt_valid) begin
            pkts_seen++;
            if (exp_len_q.size() == 0) begin
                chk("R7 unexpected packet", 1, 0);
            end else begin
                int n;
                n = exp_len_q.pop_front();
                chk("R7 pkt_len", 32'(pkt_len), n);
                for (int i = 0; i < n; i++) begin
                    out_rd_addr = 4'(i);
                    #0.1;
                    chk("R12 packet byte", out_rd_data, exp_byte_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 treq_n", treq_n, 1);
        chk("R1 shift_irq", shift_irq, 0);
        chk("R1 pkt_valid", pkt_valid, 0);
        chk("R1 sr_q", sr_q, 0);

        // Host-to-device packets: normal and overflowing.
        host_send(3, 8'hA0);
        host_send(18, 8'h40);

        // Idle sync: request follows acknowledge.
        step(); step();
        clear_irq();
        tack_n = ~tack_n; step();
        chk("R6 treq follows tack", treq_n, tack_n);
        chk("R6 sync irq", shift_irq, 1);
        clear_irq();
        chk("R10 ack clears", shift_irq, 0);
        tack_n = ~tack_n; step();
        chk("R6 treq follows tack again", treq_n, tack_n);
        if (tack_n == 1'b0) begin tack_n = 1'b1; step(); end

        // Device-to-host: load three bytes and commit.
        in_wr_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            in_wr_addr = 7'(i); in_wr_data = 8'h11 * 8'(i + 1); step();
        end
        in_wr_en = 1'b0;
        in_commit = 1'b1; in_len = 8'd3; step(); in_commit = 1'b0;
        step();
        chk("R8 R9 treq asserted", treq_n, 0);
        dir_out = 1'b0;
        tip_n = 1'b0; step();
        chk("R4 first byte", sr_q, 8'h11);
        chk("R4 irq", shift_irq, 1);
        clear_irq();
        step();
        chk("R4 no change keeps sr", sr_q, 8'h11);
        chk("R4 no change keeps irq", shift_irq, 0);
        sr_ack = 1'b1; tack_n = ~tack_n; step(); sr_ack = 1'b0;
        chk("R4 second byte", sr_q, 8'h22);
        chk("R10 set wins over ack", shift_irq, 1);
        chk("R5 treq still low", treq_n, 0);
        tack_n = ~tack_n; step();
        chk("R4 third byte", sr_q, 8'h33);
        chk("R5 treq released on last", treq_n, 1);
        clear_irq();
        tack_n = ~tack_n; step();
        chk("R4 none pending sr", sr_q, 8'h33);
        chk("R4 none pending irq", shift_irq, 0);
        tip_n = 1'b1; step();
        chk("R7 release irq input dir", shift_irq, 1);
        chk("R7 no packet input dir", pkt_valid, 0);
        step();

        chk("R7 packets seen", pkts_seen, 2);
        chk("R7 queue drained", exp_len_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule